// File: doc/BRIEF.md
# AES Key Expansion Step Unit

This block derives one new 128-bit AES round-key group per operation. It works on several independent key groups side by side (parameter `GROUPS`), all expanded with the same mode and round number. In AES-128 mode it uses the current group. In AES-256 mode it uses the newer and older of the two preceding groups. The round number is an operand of each call, so the block keeps no schedule state: a caller runs a full schedule by feeding each result back with the next round number.

Operands enter on a valid/ready input port and the result leaves on a valid/ready output port. One result register sits between them. A new operation is accepted when the register is empty or when its content is being taken in the same cycle. The result appears one cycle after acceptance. While the consumer holds `out_ready` low, `out_valid` and `out_key` stay unchanged and `in_ready` is low, so the back-pressure reaches the producer. The mode and round-number pins belong to the input operand and are sampled with it.

Word w of a group sits in bits 32w+31:32w. Byte b of a word sits in bits 8b+7:8b. The S-box is the standard AES forward substitution. It is computed in logic, and each group uses one instance for both modes.

Top module: `aes_kexp_step`

## Requirements
- R1: In AES-128 mode (`in_mode`=0), new word 0 = S(rot(w3)) XOR {24'b0, rcon} XOR w0. Here w0..w3 are the words of `in_key_new`, rot(x) = {x[7:0], x[31:8]}, S substitutes each byte, and rcon is the constant for the effective round number.
- R2: Words 1 to 3 of a result are chained: new word i = new word i-1 XOR base word i. The base group is `in_key_new` in AES-128 mode and `in_key_old` in AES-256 mode.
- R3: Ten AES-128 steps with rounds 1 to 10, each fed the previous result, turn key bytes 00..0f into final round key bytes 13 11 1d 7f e3 94 4a 17 f3 07 a7 8b 4d 2b 30 c5.
- R4: In AES-256 mode (`in_mode`=1) with an even effective round e, new word 0 = S(rot(w3 of `in_key_new`)) XOR {24'b0, rcon(e/2)} XOR w0 of `in_key_old`.
- R5: In AES-256 mode with an odd effective round, new word 0 = S(w3 of `in_key_new`) XOR w0 of `in_key_old`, with no rotation and no constant.
- R6: In AES-128 mode, a round of 0 or above 10 has bit 3 flipped before use. For example, round 0 uses constant 80 and round 12 uses 08.
- R7: In AES-256 mode, a round below 2 or above 14 has bit 3 flipped before use. For example, round 0 acts as even round 8 and round 1 as odd round 9.
- R8: S is the AES forward S-box, with S(00)=63. Constants rcon(1..10) are 01,02,04,08,10,20,40,80,1b,36.
- R9: Each key group is expanded independently of the others, with the shared mode and round number.
- R10: `out_valid` rises in the cycle after an accepted input. It then holds with `out_key` stable until `out_ready` is sampled high.
- R11: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R12: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand accepted when high with in_valid |
| in_mode | input | 1 | 0 = AES-128 step, 1 = AES-256 step |
| in_round | input | 4 | Round-number operand |
| in_key_new | input | GROUPS*128 | Current (newer) group per lane |
| in_key_old | input | GROUPS*128 | Older group per lane, AES-256 only |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_key | output | GROUPS*128 | New group per lane |

## Verification
Every result is due exactly one cycle after the edge where `in_valid` and `in_ready` are both high. `in_ready` depends on the state in the same cycle. The bench keeps a behavioural model that is updated at each rising edge from the same handshake rule. It compares `out_valid`, `in_ready` and, whenever a result is held, `out_key` at every falling edge. Inputs change 2 ns after the rising edge, so the model and the design see the same operands. Directed steps with known values check the round remapping, the odd/even AES-256 split and the full AES-128 schedule. A random phase covers back-pressure.

// File: rtl/aes_kexp_pkg.sv
package aes_kexp_pkg;
  localparam int WORD_W  = 32;
  localparam int GROUP_W = 128;
  localparam int WORDS   = GROUP_W / WORD_W;

  typedef enum logic {
    KX_AES128 = 1'b0,
    KX_AES256 = 1'b1
  } kx_mode_e;

  function automatic logic [7:0] gf_xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xt(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254, then the forward affine map
  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] sq;
    logic [7:0] e;
    r  = 8'h01;
    sq = a;
    e  = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, sq);
      sq = gf_mul(sq, sq);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
             ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  // round constant: 01 doubled idx-1 times; index 0 yields 00
  function automatic logic [7:0] rcon_of(input logic [3:0] idx);
    logic [7:0] c;
    c = 8'h01;
    for (int i = 2; i < 16; i++) begin
      if (i <= int'(idx)) c = gf_xt(c);
    end
    return (idx == 4'd0) ? 8'h00 : c;
  endfunction
endpackage

// File: rtl/aes_kexp_sbox_word.sv
module aes_kexp_sbox_word
  import aes_kexp_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int BYTES = WORD_W / 8;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_comb dout[8*b +: 8] = sbox_fwd(din[8*b +: 8]);
  end
endmodule

// File: rtl/aes_kexp_round_ctl.sv
module aes_kexp_round_ctl
  import aes_kexp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chk_en,
  input  kx_mode_e   mode,
  input  logic [3:0] round,
  output logic       rot_en,
  output logic [7:0] rcon
);
  logic [3:0] eff;
  logic [3:0] rc_idx;

  always_comb begin
    eff    = round;
    rot_en = 1'b1;
    rc_idx = 4'd0;
    if (mode == KX_AES128) begin
      if (round == 4'd0 || round > 4'd10) eff = round ^ 4'b1000;
      rc_idx = eff;
    end else begin
      if (round < 4'd2 || round > 4'd14) eff = round ^ 4'b1000;
      rot_en = ~eff[0];
      rc_idx = eff[0] ? 4'd0 : {1'b0, eff[3:1]};
    end
    rcon = rcon_of(rc_idx);
  end

  // R6: after remapping an AES-128 step always has a defined non-zero constant
  assert_rcon_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && mode == KX_AES128) |-> (rcon != 8'h00));
  // R5: odd AES-256 steps carry no rotation and no constant
  assert_odd_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && mode == KX_AES256 && round > 4'd1 && round < 4'd15 && round[0])
      |-> (!rot_en && rcon == 8'h00));
  // R7: round 1 in AES-256 mode behaves as odd round 9
  assert_remap_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && mode == KX_AES256 && round == 4'd1) |-> !rot_en);
endmodule

// File: rtl/aes_kexp_lane.sv
module aes_kexp_lane
  import aes_kexp_pkg::*;
(
  input  kx_mode_e           mode,
  input  logic               rot_en,
  input  logic [7:0]         rcon,
  input  logic [GROUP_W-1:0] key_new,
  input  logic [GROUP_W-1:0] key_old,
  output logic [GROUP_W-1:0] key_next
);
  logic [WORD_W-1:0]  last_w;
  logic [WORD_W-1:0]  sb_in;
  logic [WORD_W-1:0]  sb_out;
  logic [WORD_W-1:0]  mix;
  logic [GROUP_W-1:0] base;

  assign last_w = key_new[GROUP_W-1 -: WORD_W];
  assign sb_in  = rot_en ? {last_w[7:0], last_w[WORD_W-1:8]} : last_w;

  // one substitution word per lane, used by both schedules
  aes_kexp_sbox_word u_sbox (
    .din  (sb_in),
    .dout (sb_out)
  );

  assign mix  = sb_out ^ {{(WORD_W-8){1'b0}}, rcon};
  assign base = (mode == KX_AES128) ? key_new : key_old;

  assign key_next[WORD_W-1:0] = mix ^ base[WORD_W-1:0];
  for (genvar w = 1; w < WORDS; w++) begin : g_chain
    assign key_next[WORD_W*w +: WORD_W] =
      key_next[WORD_W*(w-1) +: WORD_W] ^ base[WORD_W*w +: WORD_W];
  end
endmodule

// File: rtl/aes_kexp_step.sv
module aes_kexp_step
  import aes_kexp_pkg::*;
#(
  parameter int GROUPS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_mode,
  input  logic [3:0]              in_round,
  input  logic [GROUPS*128-1:0]   in_key_new,
  input  logic [GROUPS*128-1:0]   in_key_old,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [GROUPS*128-1:0]   out_key
);
  localparam int BUS_W = GROUPS * GROUP_W;

  kx_mode_e         mode;
  logic             rot_en;
  logic [7:0]       rcon;
  logic [BUS_W-1:0] next_key;
  logic             accept;

  assign mode     = kx_mode_e'(in_mode);
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  aes_kexp_round_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .chk_en (in_valid),
    .mode   (mode),
    .round  (in_round),
    .rot_en (rot_en),
    .rcon   (rcon)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    aes_kexp_lane u_lane (
      .mode     (mode),
      .rot_en   (rot_en),
      .rcon     (rcon),
      .key_new  (in_key_new[GROUP_W*g +: GROUP_W]),
      .key_old  (in_key_old[GROUP_W*g +: GROUP_W]),
      .key_next (next_key[GROUP_W*g +: GROUP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) out_key <= next_key;
  end

  // R10: acceptance produces a result in the next cycle
  assert_result_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R10: a stalled result holds its value
  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_key)));
  // R2: word 1 of lane 0 equals word 0 XOR the base group's word 1
  assert_chain_w1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      ((out_key[63:32] ^ out_key[31:0]) ==
       ($past(in_mode) ? $past(in_key_old[63:32]) : $past(in_key_new[63:32]))));
endmodule

// File: tb/aes_kexp_step_tb_top.sv
module aes_kexp_step_tb_top;
  localparam int G = 2;
  localparam int W = G * 128;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic         in_mode;
  logic [3:0]   in_round;
  logic [W-1:0] in_key_new;
  logic [W-1:0] in_key_old;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_key;

  always #4 clk = ~clk;

  aes_kexp_step #(.GROUPS(G)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_round(in_round), .in_key_new(in_key_new),
    .in_key_old(in_key_old), .out_valid(out_valid), .out_ready(out_ready),
    .out_key(out_key)
  );

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  string req = "R1";
  logic [7:0] sb [256];
  logic [7:0] rc [16];
  logic         exp_valid;
  logic [W-1:0] exp_key;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // S-box built from log/antilog tables over generator 03
  task automatic build_tables();
    logic [7:0] ex [256];
    int lg [256];
    logic [7:0] v, inv, s;
    v = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = v;
      lg[v] = i;
      v = v ^ xt(v);
    end
    for (int x = 0; x < 256; x++) begin
      inv = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      s = 8'h63;
      for (int k = 0; k < 5; k++) s = s ^ ((inv << k) | (inv >> (8 - k)));
      sb[x] = s;
    end
    rc[0] = 8'h00;
    rc[1] = 8'h01;
    for (int i = 2; i < 16; i++) rc[i] = xt(rc[i-1]);
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = sb[w[8*k +: 8]];
    return r;
  endfunction

  function automatic logic [127:0] ref_grp(input bit m, input int r,
                                           input logic [127:0] nw,
                                           input logic [127:0] od);
    int e;
    logic [31:0] w3, rw, t;
    logic [127:0] base, res;
    w3 = nw[127:96];
    for (int k = 0; k < 4; k++) rw[8*k +: 8] = w3[8*((k+1)%4) +: 8];
    if (!m) begin
      e = (r == 0 || r > 10) ? (r ^ 8) : r;
      t = subw(rw) ^ {24'h0, rc[e]};
      base = nw;
    end else begin
      e = (r < 2 || r > 14) ? (r ^ 8) : r;
      if (e % 2 == 0) t = subw(rw) ^ {24'h0, rc[e/2]};
      else t = subw(w3);
      base = od;
    end
    res[31:0] = t ^ base[31:0];
    for (int k = 1; k < 4; k++) res[32*k +: 32] = res[32*(k-1) +: 32] ^ base[32*k +: 32];
    return res;
  endfunction

  function automatic logic [W-1:0] ref_all(input bit m, input int r,
                                           input logic [W-1:0] nw, input logic [W-1:0] od);
    logic [W-1:0] o;
    for (int g = 0; g < G; g++) o[128*g +: 128] = ref_grp(m, r, nw[128*g +: 128], od[128*g +: 128]);
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // behavioural reference of the handshake
  always @(posedge clk) begin
    if (!rst_n) exp_valid <= 1'b0;
    else if (in_valid && (!exp_valid || out_ready)) begin
      exp_valid <= 1'b1;
      exp_key <= ref_all(in_mode, int'(in_round), in_key_new, in_key_old);
    end else if (out_ready) exp_valid <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid === exp_valid, "R10", W'(out_valid), W'(exp_valid));
      chk(in_ready === (!exp_valid || out_ready), "R11", W'(in_ready), W'(!exp_valid || out_ready));
      if (exp_valid) chk(out_key === exp_key, req, out_key, exp_key);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic do_op(input bit m, input int r, input logic [W-1:0] nw,
                       input logic [W-1:0] od, output logic [W-1:0] res);
    @(posedge clk); #2;
    in_valid = 1'b1; in_mode = m; in_round = 4'(r);
    in_key_new = nw; in_key_old = od;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    if (!out_valid) @(negedge clk);
    res = out_key;
  endtask

  function automatic logic [W-1:0] rnd_bus();
    logic [W-1:0] v;
    for (int k = 0; k < W / 32; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [W-1:0] res, cur, oth;
    build_tables();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_mode = 1'b0;
    in_round = 4'd0; in_key_new = '0; in_key_old = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R12", W'(out_valid), W'(0));
    @(posedge clk); #2; rst_n = 1'b1;

    // R8 / R9: zero key in lane 0, random key in lane 1
    oth = rnd_bus();
    req = "R8";
    do_op(1'b0, 1, {oth[255:128], 128'h0}, '0, res);
    chk(res[127:0] === {4{32'h63636362}}, "R8", W'(res[127:0]), W'({4{32'h63636362}}));
    chk(res[255:128] === ref_grp(1'b0, 1, oth[255:128], 128'h0), "R9",
        W'(res[255:128]), W'(ref_grp(1'b0, 1, oth[255:128], 128'h0)));

    // R6: remapped AES-128 rounds
    req = "R6";
    do_op(1'b0, 0, '0, '0, res);
    chk(res[31:0] === 32'h636363e3, "R6", W'(res[31:0]), W'(32'h636363e3));
    do_op(1'b0, 12, '0, '0, res);
    chk(res[31:0] === 32'h6363636b, "R6", W'(res[31:0]), W'(32'h6363636b));

    // R5 / R7: AES-256 odd and remapped rounds
    req = "R5";
    do_op(1'b1, 3, '0, '0, res);
    chk(res[31:0] === 32'h63636363, "R5", W'(res[31:0]), W'(32'h63636363));
    req = "R7";
    do_op(1'b1, 0, '0, '0, res);
    chk(res[31:0] === 32'h6363636b, "R7", W'(res[31:0]), W'(32'h6363636b));
    do_op(1'b1, 1, '0, '0, res);
    chk(res[31:0] === 32'h63636363, "R7", W'(res[31:0]), W'(32'h63636363));

    // R3: complete AES-128 schedule, result fed back
    req = "R3";
    cur = {rnd_bus()[255:128], 128'h0f0e0d0c_0b0a0908_07060504_03020100};
    for (int r = 1; r <= 10; r++) begin
      do_op(1'b0, r, cur, '0, res);
      cur = res;
    end
    chk(cur[127:0] === 128'hc5302b4d_8ba707f3_174a94e3_7f1d1113, "R3",
        W'(cur[127:0]), W'(128'hc5302b4d_8ba707f3_174a94e3_7f1d1113));

    // R1 / R2 / R4: every round in both modes with random keys
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 16; r++) begin
        req = (m == 0) ? "R1" : "R4";
        do_op(m[0], r, rnd_bus(), rnd_bus(), res);
      end
    end
    req = "R2";
    cur = rnd_bus(); oth = rnd_bus();
    do_op(1'b1, 6, cur, oth, res);
    chk((res[63:32] ^ res[31:0]) === oth[63:32], "R2", W'(res[63:32] ^ res[31:0]), W'(oth[63:32]));

    // R10 / R11: back-pressure and random traffic
    req = "R10";
    @(posedge clk); #2;
    out_ready = 1'b0; in_valid = 1'b1; in_mode = 1'b0; in_round = 4'd5;
    in_key_new = rnd_bus(); in_key_old = rnd_bus();
    repeat (6) @(posedge clk);
    #2 out_ready = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #2;
      in_valid = $urandom_range(0, 1);
      out_ready = ($urandom_range(0, 3) != 0);
      in_mode = $urandom_range(0, 1);
      in_round = 4'($urandom_range(0, 15));
      in_key_new = rnd_bus(); in_key_old = rnd_bus();
    end
    @(posedge clk); #2; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule